// File: doc/BRIEF.md
# Transmit Prefetch FIFO with Underflow Detection

This block feeds the transmit side of a serial peripheral. Firmware places outgoing words in a circular window of a shared word memory. The window is set by a base and a limit address. Firmware then tells the block how many bytes it added. The block keeps the read pointer and the write pointer, and it counts the words held in the window. It fetches words from the memory into a two-entry staging queue, and only the oldest staged word is shown to the serial shifter.

When the shifter asks for a word and nothing is staged, in flight or held, the block returns an all-zero filler word. It then raises a one-cycle underflow event. A second event fires when the count of held words falls below a watermark. The watermark is given in bytes and rounded up to whole words. Both events are single-cycle pulses meant for a shared interrupt register set. The configuration is held steady while the block is out of reset, and the limit word is never below the base word.

Top module: `tx_prefetch_fifo`

## Requirements
- R1: During reset and in the first cycle after it, the filled byte count reads 0, both pointers equal the base word, no event is raised, and the shifter data reads zero.
- R2: The window bounds are the base and limit addresses with their two low bits ignored (word addresses base_w and limit_w). The window size is limit_w - base_w + 1 words.
- R3: An advance request of B bytes adds min(floor(B/4), size - held) words; the two low bits of B are dropped. The write pointer moves by the added count and wraps past limit_w back to base_w. filled_bytes reports 4 times the held word count.
- R4: mem_req is high whenever at least one word is held and the staged plus in-flight words number fewer than two. mem_addr equals the read pointer. Each request moves the read pointer one word, from limit_w back to base_w at the end, and lowers the held count by one.
- R5: The memory returns data in the cycle after a request, and that word enters the tail of the staging queue.
- R6: shf_data shows only the oldest staged word. A request in a cycle with a staged word consumes it, and the next word is shown only afterwards. Words reach the shifter in the order firmware wrote them.
- R7: A request made when nothing is staged, nothing is in flight and no word is held returns an all-zero shf_data. evt_underflow is then high for exactly the next cycle, and neither pointer moves.
- R8: A request made with nothing staged while a word is held or in flight returns all-zero shf_data. It raises no underflow event and loses no word.
- R9: With threshold T = ceil(wmark/4) words, evt_below is a one-cycle pulse. It appears in the cycle after the held count first becomes less than T.
- R10: evt_below fires only when the below-threshold condition goes from false to true. The state right after reset counts as already below, so no event follows reset.
- R11: A watermark of 0, or one above 4 times the window size in bytes, never produces evt_below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Window base byte address (low 2 bits ignored) |
| cfg_limit | input | ADDR_W | Window limit byte address (low 2 bits ignored) |
| cfg_wmark | input | ADDR_W+1 | Transmit watermark in bytes |
| fw_adv_valid | input | 1 | Firmware advance request |
| fw_adv_bytes | input | ADDR_W+1 | Bytes added by firmware |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_rdata | input | DATA_W | Memory read data, one cycle after request |
| shf_req | input | 1 | Shifter requests a word |
| shf_data | output | DATA_W | Oldest staged word, zero when none |
| evt_below | output | 1 | Below-watermark event pulse |
| evt_underflow | output | 1 | Underflow event pulse |
| rd_ptr | output | ADDR_W-2 | Read pointer, word address |
| wr_ptr | output | ADDR_W-2 | Write pointer, word address |
| filled_bytes | output | ADDR_W+1 | Bytes held in the window |

## Verification
The bench builds the block with ADDR_W = 6, which gives a 16-word memory. At that size every base/limit pair (136 windows) can be swept, covering every wrap position and window sizes from one word to the whole memory. Each window is run with two watermarks drawn from zero, one byte, the exact window size, one byte over it, a value that rounds up, and a middle value. This covers both the disabled cases and the rounding rule. Non-zero low address bits on the bounds, clamped advances, requests during a fetch, and underflow both before the first fill and after a full drain all fall inside each run.

// File: rtl/tx_fifo_pkg.sv
// Shared constants and types for the transmit prefetch FIFO.
// Assumes a 32-bit memory word addressed in bytes.
package tx_fifo_pkg;
    localparam int WORD_BYTES = 4;
    localparam int BYTE_SHIFT = 2;

    // Occupancy of the two-entry staging queue.
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_ONE   = 2'd1,
        Q_TWO   = 2'd2
    } q_fill_e;
endpackage

// File: rtl/tx_win_ptr.sv
// Circular word pointer inside a base/limit window.
// Adds a step of 0..size each cycle and wraps past limit back to base.
// Assumes base <= limit and that the window is stable outside reset.
module tx_win_ptr #(
    parameter int WA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WA_W-1:0] base_w,
    input  logic [WA_W-1:0] limit_w,
    input  logic [WA_W:0]   size_w,
    input  logic [WA_W:0]   step,
    output logic [WA_W-1:0] ptr
);
    logic [WA_W+1:0] sum;
    logic [WA_W+1:0] wrapped;

    // Next position with one wrap correction.
    always_comb begin
        sum     = {2'b00, ptr} + {1'b0, step};
        wrapped = (sum > {2'b00, limit_w}) ? (sum - {1'b0, size_w}) : sum;
    end

    // Pointer register, loads base in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= base_w;
        else        ptr <= WA_W'(wrapped);
    end

    a_r4_ptr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr >= base_w) && (ptr <= limit_w));
endmodule

// File: rtl/tx_stage_queue.sv
// Two-entry staging queue between memory and shifter.
// Only the oldest entry is visible; the second one is exposed once the
// first has been consumed. Push and pop may occur in the same cycle.
module tx_stage_queue
    import tx_fifo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [1:0]        cnt
);
    q_fill_e           fill_q;
    logic [DATA_W-1:0] ent0;
    logic [DATA_W-1:0] ent1;
    logic              take;

    // A pop only counts when a word is staged.
    assign take = pop && (fill_q != Q_EMPTY);

    // Entry and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= Q_EMPTY;
            ent0   <= '0;
            ent1   <= '0;
        end else begin
            case (fill_q)
                Q_EMPTY: begin
                    if (push) begin
                        ent0   <= push_data;
                        fill_q <= Q_ONE;
                    end
                end
                Q_ONE: begin
                    if (push && take) begin
                        ent0 <= push_data;
                    end else if (push) begin
                        ent1   <= push_data;
                        fill_q <= Q_TWO;
                    end else if (take) begin
                        fill_q <= Q_EMPTY;
                    end
                end
                Q_TWO: begin
                    if (take) begin
                        ent0 <= ent1;
                        if (push) ent1   <= push_data;
                        else      fill_q <= Q_ONE;
                    end
                end
                default: fill_q <= Q_EMPTY;
            endcase
        end
    end

    assign head = ent0;
    assign cnt  = fill_q;

    a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((fill_q != Q_TWO) || take));
endmodule

// File: rtl/tx_level_event.sv
// Below-watermark event generator.
// The watermark in bytes is rounded up to words. The compare is registered,
// and a pulse is raised on the rising edge of the below condition. A zero
// watermark, or one above the window byte size, disables the event.
module tx_level_event
    import tx_fifo_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-2:0] filled_w,
    input  logic [ADDR_W-2:0] size_w,
    input  logic [ADDR_W:0]   wmark,
    output logic              evt
);
    logic [ADDR_W+1:0] wm_round;
    logic [ADDR_W-1:0] thr_w;
    logic [ADDR_W:0]   size_b;
    logic              wm_ok;
    logic              below;
    logic              below_q;

    // Threshold in words and enable decision.
    always_comb begin
        wm_round = {1'b0, wmark} + (ADDR_W+2)'(WORD_BYTES - 1);
        thr_w    = ADDR_W'(wm_round >> BYTE_SHIFT);
        size_b   = {size_w, 2'b00};
        wm_ok    = (wmark != '0) && (wmark <= size_b);
        below    = wm_ok && ({1'b0, filled_w} < thr_w);
    end

    // Registered condition and rising-edge pulse; reset counts as below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            below_q <= 1'b1;
            evt     <= 1'b0;
        end else begin
            below_q <= below;
            evt     <= below && !below_q;
        end
    end

    a_r11_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(wm_ok));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/tx_prefetch_fifo.sv
// Transmit prefetch FIFO: tracks the words held in a base/limit memory
// window, fetches them into a two-entry staging queue, serves the shifter,
// and raises below-watermark and underflow events.
// Assumes memory read latency of one cycle, a stable configuration outside
// reset, and limit word >= base word.
module tx_prefetch_fifo
    import tx_fifo_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [ADDR_W:0]   cfg_wmark,
    input  logic              fw_adv_valid,
    input  logic [ADDR_W:0]   fw_adv_bytes,
    output logic              mem_req,
    output logic [ADDR_W-3:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              shf_req,
    output logic [DATA_W-1:0] shf_data,
    output logic              evt_below,
    output logic              evt_underflow,
    output logic [ADDR_W-3:0] rd_ptr,
    output logic [ADDR_W-3:0] wr_ptr,
    output logic [ADDR_W:0]   filled_bytes
);
    localparam int WA_W  = ADDR_W - 2;
    localparam int CNT_W = WA_W + 1;

    logic [WA_W-1:0]   base_w;
    logic [WA_W-1:0]   limit_w;
    logic [CNT_W-1:0]  size_w;
    logic [CNT_W-1:0]  filled_q;
    logic [CNT_W-1:0]  adv_words;
    logic [CNT_W-1:0]  free_w;
    logic [CNT_W-1:0]  acc_w;
    logic [CNT_W-1:0]  rd_step;
    logic              inflight_q;
    logic [1:0]        q_cnt;
    logic [1:0]        occ;
    logic [DATA_W-1:0] q_head;
    logic              udf_hit;

    // Window bounds in words; low address bits dropped.
    always_comb begin
        base_w  = WA_W'(cfg_base >> BYTE_SHIFT);
        limit_w = WA_W'(cfg_limit >> BYTE_SHIFT);
        size_w  = {1'b0, limit_w} - {1'b0, base_w} + CNT_W'(1);
    end

    // Accepted firmware words, clamped to the free space.
    always_comb begin
        adv_words = CNT_W'(fw_adv_bytes >> BYTE_SHIFT);
        free_w    = size_w - filled_q;
        if (!fw_adv_valid)         acc_w = '0;
        else if (adv_words < free_w) acc_w = adv_words;
        else                       acc_w = free_w;
    end

    // Fetch decision: a held word and room for it in queue plus flight.
    always_comb begin
        occ      = q_cnt + {1'b0, inflight_q};
        mem_req  = (filled_q != '0) && (occ < 2'd2);
        mem_addr = rd_ptr;
        rd_step  = CNT_W'(mem_req);
    end

    // Held word count and fetch-in-flight flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled_q   <= '0;
            inflight_q <= 1'b0;
        end else begin
            filled_q   <= filled_q + acc_w - rd_step;
            inflight_q <= mem_req;
        end
    end

    tx_win_ptr #(.WA_W(WA_W)) i_rd_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_w  (base_w),
        .limit_w (limit_w),
        .size_w  (size_w),
        .step    (rd_step),
        .ptr     (rd_ptr)
    );

    tx_win_ptr #(.WA_W(WA_W)) i_wr_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_w  (base_w),
        .limit_w (limit_w),
        .size_w  (size_w),
        .step    (acc_w),
        .ptr     (wr_ptr)
    );

    tx_stage_queue #(.DATA_W(DATA_W)) i_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (inflight_q),
        .push_data (mem_rdata),
        .pop       (shf_req),
        .head      (q_head),
        .cnt       (q_cnt)
    );

    // Shifter view: oldest staged word or the zero filler.
    assign shf_data = (q_cnt != 2'd0) ? q_head : '0;

    // Underflow: nothing staged, nothing in flight, nothing held.
    assign udf_hit = shf_req && (q_cnt == 2'd0) && !inflight_q && (filled_q == '0);

    // Underflow event register.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_underflow <= 1'b0;
        else        evt_underflow <= udf_hit;
    end

    tx_level_event #(.ADDR_W(ADDR_W)) i_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .filled_w (filled_q),
        .size_w   (size_w),
        .wmark    (cfg_wmark),
        .evt      (evt_below)
    );

    assign filled_bytes = {filled_q, 2'b00};

    a_r3_filled_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        filled_q <= size_w);
    a_r4_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= 2'd2);
    a_r7_udf_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        evt_underflow |-> $stable(rd_ptr));
endmodule

// File: tb/test_tx_prefetch_fifo.sv
module test_tx_prefetch_fifo;
    localparam int ADDR_W = 6;
    localparam int WORDS  = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [ADDR_W-1:0] cfg_limit = '0;
    logic [ADDR_W:0]   cfg_wmark = '0;
    logic              fw_adv_valid = 1'b0;
    logic [ADDR_W:0]   fw_adv_bytes = '0;
    logic              mem_req;
    logic [ADDR_W-3:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              shf_req = 1'b0;
    logic [DATA_W-1:0] shf_data;
    logic              evt_below;
    logic              evt_underflow;
    logic [ADDR_W-3:0] rd_ptr;
    logic [ADDR_W-3:0] wr_ptr;
    logic [ADDR_W:0]   filled_bytes;

    always #5 clk = ~clk;

    tx_prefetch_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tx_prefetch_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .cfg_wmark(cfg_wmark), .fw_adv_valid(fw_adv_valid), .fw_adv_bytes(fw_adv_bytes),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .shf_req(shf_req), .shf_data(shf_data), .evt_below(evt_below),
        .evt_underflow(evt_underflow), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .filled_bytes(filled_bytes)
    );

    // Shared word memory with one-cycle read latency.
    logic [31:0] mem [WORDS];
    always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr];

    int n_chk = 0, n_bad = 0;
    int cnt_below = 0, cnt_udf = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_below) cnt_below++;
            if (evt_underflow) cnt_udf++;
        end
    end

    // Reference model state.
    int size, base_m, limit_m, filled_m, staged_m, rd_m, wr_m;
    int exp_below, exp_udf, thr, wm, tok;
    bit wm_ok, cprev;
    logic [31:0] exp_q [$];

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void apply_cond(int f);
        bit c;
        c = wm_ok && (f < thr);
        if (c && !cprev) exp_below++;
        cprev = c;
    endfunction

    function automatic int wrap1(int p);
        return (p == limit_m) ? base_m : p + 1;
    endfunction

    // Prefetch in the model: one word per cycle while room remains.
    function automatic void settle();
        while (filled_m > 0 && staged_m < 2) begin
            filled_m--;
            staged_m++;
            rd_m = wrap1(rd_m);
            apply_cond(filled_m);
        end
    endfunction

    task automatic check_state(string ctx);
        chk(filled_bytes == (ADDR_W+1)'(filled_m * 4), "R3", {ctx, " filled_bytes"}, filled_bytes, filled_m * 4);
        chk(rd_ptr == 4'(rd_m), "R2 R4", {ctx, " rd_ptr"}, rd_ptr, rd_m);
        chk(wr_ptr == 4'(wr_m), "R2 R3", {ctx, " wr_ptr"}, wr_ptr, wr_m);
        chk(cnt_below == exp_below, wm_ok ? "R9 R10" : "R11", {ctx, " below events"}, cnt_below, exp_below);
        chk(cnt_udf == exp_udf, "R7 R8", {ctx, " underflow events"}, cnt_udf, exp_udf);
    endtask

    task automatic udf_probe(string ctx);
        chk(shf_data == '0, "R7", {ctx, " filler"}, shf_data, 0);
        shf_req = 1'b1;
        tick();
        shf_req = 1'b0;
        chk(evt_underflow == 1'b1, "R7", {ctx, " event"}, evt_underflow, 1);
        exp_udf++;
        tick();
        chk(evt_underflow == 1'b0, "R7", {ctx, " event width"}, evt_underflow, 0);
        check_state(ctx);
    endtask

    task automatic adv(int words_req, int extra);
        int fr, acc;
        bit probe;
        fr = size - filled_m;
        acc = (words_req < fr) ? words_req : fr;
        probe = (filled_m == 0) && (staged_m == 0) && (acc > 0);
        for (int i = 0; i < acc; i++) begin
            tok++;
            mem[wr_m] = (32'(tok) * 32'h9E3779B1) ^ 32'h5A5A0000;
            exp_q.push_back(mem[wr_m]);
            wr_m = wrap1(wr_m);
        end
        fw_adv_bytes = (ADDR_W+1)'(words_req * 4 + extra);
        fw_adv_valid = 1'b1;
        tick();
        fw_adv_valid = 1'b0;
        filled_m += acc;
        apply_cond(filled_m);
        if (probe) begin
            // R8: fetch just issued, nothing staged yet.
            chk(shf_data == '0, "R8", "filler during fetch", shf_data, 0);
            shf_req = 1'b1;
            tick();
            shf_req = 1'b0;
            chk(evt_underflow == 1'b0, "R8", "no underflow during fetch", evt_underflow, 0);
        end
        repeat (5) tick();
        settle();
        check_state("advance");
    endtask

    task automatic pop_one();
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(shf_data == e, "R5 R6", "shifter word", shf_data, e);
        shf_req = 1'b1;
        tick();
        shf_req = 1'b0;
        staged_m--;
        repeat (4) tick();
        settle();
        check_state("pop");
    endtask

    task automatic run(int bw, int lw, int wsel, int idx);
        size = lw - bw + 1;
        base_m = bw;
        limit_m = lw;
        case (wsel)
            0: wm = 0;
            1: wm = 1;
            2: wm = 4 * size;
            3: wm = 4 * size + 1;
            4: wm = 4 * size - 3;
            default: wm = 2 * size + 2;
        endcase
        wm_ok = (wm != 0) && (wm <= 4 * size);
        thr = (wm + 3) / 4;
        rst_n = 1'b0;
        cfg_base = ADDR_W'(bw * 4 + idx % 4);
        cfg_limit = ADDR_W'(lw * 4 + (idx + 1) % 4);
        cfg_wmark = (ADDR_W+1)'(wm);
        repeat (3) tick();
        filled_m = 0; staged_m = 0; rd_m = bw; wr_m = bw;
        exp_below = 0; exp_udf = 0; cprev = 1'b1;
        cnt_below = 0; cnt_udf = 0;
        exp_q.delete();
        rst_n = 1'b1;
        apply_cond(0);
        tick();
        // R1: state just after reset.
        chk(evt_below == 1'b0 && evt_underflow == 1'b0, "R1", "events after reset",
            {evt_below, evt_underflow}, 0);
        chk(shf_data == '0, "R1", "shifter data after reset", shf_data, 0);
        check_state("R1 reset");
        udf_probe("empty after reset");
        adv(size / 2, 1);
        adv(size + 3, 2);
        while (staged_m > 0) pop_one();
        udf_probe("after drain");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int idx;
        idx = 0;
        tok = 0;
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
        @(negedge clk);
        for (int bw = 0; bw < WORDS; bw++) begin
            for (int lw = bw; lw < WORDS; lw++) begin
                for (int k = 0; k < 2; k++) run(bw, lw, (idx + k * 3) % 6, idx);
                idx++;
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule